// File: doc/BRIEF.md
# Dual-Channel Protected Switch Fault Controller

This block holds the synchronous control and diagnostic logic for two protected high-side output channels. Each channel has a digital on/off command and three fault flags that come from external analog comparators: overcurrent, load current below the open-detect threshold, and over-temperature. Three inputs are shared by both channels. A chip enable puts the whole block to sleep. A supply overvoltage flag turns both channels off. A mode pin keeps a shorted channel on under current limit when it is high, so that loads with a large inrush current can be driven.

The block drives one gate enable per channel and one active-low status pin per channel. It also drives an active-low interrupt that combines both channels. The status pins and the interrupt pin each have an output-enable signal, so that they can go to high impedance while the block sleeps. Every asynchronous input passes through a two-flop synchronizer before use. All qualification windows are parameters counted in clock cycles: the short-sense window, the refresh (cool-down) interval and the open-sense window.

Top module: `dual_hs_fault_ctl`

## Requirements
- R1: While chip enable is low, both gate enables are 0, stat_oe and irq_oe are 0, and every timer and fault latch is reset. After enable returns with no fault flags present, both statuses and the interrupt read 1.
- R2: An overcurrent flag on a driven channel that lasts fewer than SHORT_SENSE_CYC synchronized cycles has no effect: the status stays 1 and the gate stays on.
- R3: An overcurrent flag that lasts SHORT_SENSE_CYC synchronized cycles on a driven channel drives that channel's status to 0. It does so in the cycle after the window fills, which is SHORT_SENSE_CYC+2 clock edges after the input changes.
- R4: With the mode pin low, a qualified short turns off only that channel's gate for exactly REFRESH_CYC cycles. The gate then retries, and the cycle repeats as long as the overcurrent and the command persist.
- R5: With the mode pin high, a qualified short is reported on status but the gate stays on.
- R6: The short status clears one cycle after a retry in which no overcurrent is present. It also clears within three cycles of the command going low.
- R7: With the command high and the gate on, a low-current flag that lasts OPEN_SENSE_CYC synchronized cycles drives the status to 0 while the gate stays on. The status clears once the flag drops.
- R8: With the command low, a low-current flag drives that channel's status to 0 within two synchronized cycles. The status clears when the flag drops.
- R9: Over-temperature turns off that channel's gate and drives its status to 0 two clock edges after the flag is raised. The other channel is unaffected. The gate retries when the flag clears, but the status stays 0 until the command also goes low.
- R10: A supply overvoltage turns off both gates and drives both statuses to 0, whatever the commands are. Both recover automatically when the flag clears.
- R11: While enabled, irq_n is 0 exactly when at least one status is 0. With no faults, both statuses and irq_n are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_a | input | 1 | Chip enable; low puts the block to sleep (async) |
| ovp_a | input | 1 | Supply overvoltage flag (async) |
| hold_on_short_a | input | 1 | Mode pin; high disables short latch-off (async) |
| cmd_a | input | NCH | Per-channel on/off command (async) |
| oc_a | input | NCH | Per-channel overcurrent flag (async) |
| lowcur_a | input | NCH | Per-channel flag for current below the open-detect threshold (async) |
| ot_a | input | NCH | Per-channel over-temperature flag (async) |
| gate_en | output | NCH | Per-channel gate enable |
| stat_n | output | NCH | Per-channel active-low fault status |
| stat_oe | output | 1 | Output enable for the status pins |
| irq_n | output | 1 | Active-low combined fault interrupt |
| irq_oe | output | 1 | Output enable for the interrupt pin |

## Verification
A wrong per-channel state shows first at gate_en. A cool-down counter that is off by one moves the retry edge by one cycle against the expected SHORT_SENSE_CYC+2 and REFRESH_CYC boundaries. A stuck cool-down state keeps the gate low past the retry point. Fault latches that set or clear wrongly show at stat_n within one to three cycles of the triggering input. These are the short flag after a clean retry, the thermal latch after the command falls, and the open flag after the current recovers. The bench checks each boundary one cycle before and at the expected edge. A mix-up between the channels shows as a status change on the idle channel.

// File: rtl/dhs_pkg.sv
package dhs_pkg;

  typedef enum logic {
    CH_RUN  = 1'b0,
    CH_COOL = 1'b1
  } chan_st_t;

  // last count of a window of lim cycles
  function automatic logic win_done(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dhs_sync.sv
module dhs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_a,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else begin
      chain[0] <= d_a;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dhs_chan.sv
module dhs_chan
  import dhs_pkg::*;
#(
  parameter int SHORT_SENSE_CYC = 2700,
  parameter int REFRESH_CYC     = 205000,
  parameter int OPEN_SENSE_CYC  = 320000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cmd,
  input  logic oc,
  input  logic lowcur,
  input  logic ot,
  input  logic ovp,
  input  logic hold,
  output logic gate,
  output logic fault,
  output logic short_evt
);
  localparam int MAXL = int'(max3(SHORT_SENSE_CYC, REFRESH_CYC, OPEN_SENSE_CYC));
  localparam int W    = $clog2(MAXL + 1);
  localparam logic [W-1:0] ONE = W'(1);

  chan_st_t       st;
  logic [W-1:0]   oc_cnt, rf_cnt, op_cnt;
  logic           short_f, open_f, th_f;
  logic           drive, retry_evt, open_evt;

  assign drive     = cmd && !ot && !ovp && (st == CH_RUN);
  assign short_evt = drive && oc && win_done(32'(oc_cnt), SHORT_SENSE_CYC);
  assign retry_evt = (st == CH_COOL) && win_done(32'(rf_cnt), REFRESH_CYC);
  assign open_evt  = drive && lowcur && win_done(32'(op_cnt), OPEN_SENSE_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= CH_RUN;
      oc_cnt <= '0; rf_cnt <= '0; op_cnt <= '0;
      short_f <= 1'b0; open_f <= 1'b0; th_f <= 1'b0;
    end else if (!en) begin
      st <= CH_RUN;
      oc_cnt <= '0; rf_cnt <= '0; op_cnt <= '0;
      short_f <= 1'b0; open_f <= 1'b0; th_f <= 1'b0;
    end else begin
      // qualification counters saturate at the last count of their window
      if (drive && oc)
        oc_cnt <= win_done(32'(oc_cnt), SHORT_SENSE_CYC) ? oc_cnt : oc_cnt + ONE;
      else
        oc_cnt <= '0;
      if (drive && lowcur)
        op_cnt <= win_done(32'(op_cnt), OPEN_SENSE_CYC) ? op_cnt : op_cnt + ONE;
      else
        op_cnt <= '0;
      rf_cnt <= ((st == CH_COOL) && !retry_evt) ? rf_cnt + ONE : '0;

      if (!cmd)                    st <= CH_RUN;
      else if (short_evt && !hold) st <= CH_COOL;
      else if (retry_evt)          st <= CH_RUN;

      if (!cmd)               short_f <= 1'b0;
      else if (short_evt)     short_f <= 1'b1;
      else if (drive && !oc)  short_f <= 1'b0;

      if (!cmd)               open_f <= 1'b0;
      else if (open_evt)      open_f <= 1'b1;
      else if (!lowcur)       open_f <= 1'b0;

      if (ot)                 th_f <= 1'b1;
      else if (!cmd)          th_f <= 1'b0;
    end
  end

  assign gate  = en && drive;
  assign fault = short_f | open_f | th_f | ot | ovp | (!cmd && lowcur);
endmodule

// File: rtl/dual_hs_fault_ctl.sv
module dual_hs_fault_ctl #(
  parameter int NCH             = 2,
  parameter int SYNC_STAGES     = 2,
  parameter int SHORT_SENSE_CYC = 2700,
  parameter int REFRESH_CYC     = 205000,
  parameter int OPEN_SENSE_CYC  = 320000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chip_en_a,
  input  logic           ovp_a,
  input  logic           hold_on_short_a,
  input  logic [NCH-1:0] cmd_a,
  input  logic [NCH-1:0] oc_a,
  input  logic [NCH-1:0] lowcur_a,
  input  logic [NCH-1:0] ot_a,
  output logic [NCH-1:0] gate_en,
  output logic [NCH-1:0] stat_n,
  output logic           stat_oe,
  output logic           irq_n,
  output logic           irq_oe
);
  localparam int SW = 3 + 4 * NCH;

  logic [SW-1:0]  sync_q;
  logic           en_s, ovp_s, hold_s;
  logic [NCH-1:0] cmd_s, oc_s, lowcur_s, ot_s;
  logic [NCH-1:0] fault, short_evt;

  dhs_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_a  ({chip_en_a, ovp_a, hold_on_short_a, cmd_a, oc_a, lowcur_a, ot_a}),
    .q    (sync_q)
  );

  assign {en_s, ovp_s, hold_s, cmd_s, oc_s, lowcur_s, ot_s} = sync_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dhs_chan #(
      .SHORT_SENSE_CYC(SHORT_SENSE_CYC),
      .REFRESH_CYC    (REFRESH_CYC),
      .OPEN_SENSE_CYC (OPEN_SENSE_CYC)
    ) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_s),
      .cmd      (cmd_s[c]),
      .oc       (oc_s[c]),
      .lowcur   (lowcur_s[c]),
      .ot       (ot_s[c]),
      .ovp      (ovp_s),
      .hold     (hold_s),
      .gate     (gate_en[c]),
      .fault    (fault[c]),
      .short_evt(short_evt[c])
    );
    assign stat_n[c] = en_s ? ~fault[c] : 1'b1;
  end

  assign irq_n   = en_s ? ~(|fault) : 1'b1;
  assign stat_oe = en_s;
  assign irq_oe  = en_s;
endmodule

// File: rtl/dhs_chk.sv
module dhs_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_s,
  input logic           ovp_s,
  input logic           hold_s,
  input logic [NCH-1:0] ot_s,
  input logic [NCH-1:0] short_evt,
  input logic [NCH-1:0] gate_en,
  input logic [NCH-1:0] stat_n,
  input logic           stat_oe,
  input logic           irq_n
);
  assert_sleep_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_oe |-> (gate_en == '0));

  assert_ovp_both_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && ovp_s) |-> (gate_en == '0 && stat_n == '0));

  assert_irq_combine_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_oe |-> (irq_n == &stat_n));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    assert_thermal_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_s && ot_s[c]) |-> (!gate_en[c] && !stat_n[c]));

    assert_latch_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (short_evt[c] && !hold_s) |=> !gate_en[c]);

    assert_short_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (short_evt[c] && en_s) |=> (!stat_oe || !stat_n[c]));
  end
endmodule

bind dual_hs_fault_ctl dhs_chk #(.NCH(NCH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_s     (en_s),
  .ovp_s    (ovp_s),
  .hold_s   (hold_s),
  .ot_s     (ot_s),
  .short_evt(short_evt),
  .gate_en  (gate_en),
  .stat_n   (stat_n),
  .stat_oe  (stat_oe),
  .irq_n    (irq_n)
);

// File: tb/dual_hs_fault_ctl_tb_top.sv
`timescale 1ns/1ps
module dual_hs_fault_ctl_tb_top;
  localparam int SS = 8;
  localparam int RF = 20;
  localparam int OS = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en_a = 1'b0, ovp_a = 1'b0, hold_a = 1'b0;
  logic [1:0] cmd_a = '0, oc_a = '0, lowcur_a = '0, ot_a = '0;
  logic [1:0] gate_en, stat_n;
  logic       stat_oe, irq_n, irq_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_hs_fault_ctl #(
    .NCH(2), .SYNC_STAGES(2),
    .SHORT_SENSE_CYC(SS), .REFRESH_CYC(RF), .OPEN_SENSE_CYC(OS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en_a(chip_en_a), .ovp_a(ovp_a),
    .hold_on_short_a(hold_a), .cmd_a(cmd_a), .oc_a(oc_a), .lowcur_a(lowcur_a),
    .ot_a(ot_a), .gate_en(gate_en), .stat_n(stat_n), .stat_oe(stat_oe),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go_idle();
    cmd_a = '0; oc_a = '0; lowcur_a = '0; ot_a = '0; ovp_a = 0; hold_a = 0;
    chip_en_a = 0;
    tick(4);
    check("R1 sleep gates", {2'b0, gate_en}, 4'b0000);
    check("R1 sleep oe", {2'b0, stat_oe, irq_oe}, 4'b0000);
    chip_en_a = 1;
    tick(4);
    check("R11 idle outputs", {stat_oe, irq_oe, stat_n}, 4'b1111);
    check("R11 idle irq", {3'b0, irq_n}, 4'b0001);
  endtask

  task automatic t_glitch();  // R2
    go_idle();
    cmd_a = 2'b01; tick(4);
    oc_a[0] = 1; tick(SS - 1); oc_a[0] = 0;
    tick(6);
    check("R2 short glitch status", {2'b0, stat_n}, 4'b0011);
    check("R2 short glitch gate", {2'b0, gate_en}, 4'b0001);
  endtask

  task automatic t_short_latch();  // R3 R4 R6
    go_idle();
    cmd_a = 2'b01; tick(4);
    oc_a[0] = 1;
    tick(SS + 1);
    check("R3 before window", {stat_n, gate_en}, 4'b1101);
    tick(1);
    check("R3 qualified", {stat_n, gate_en}, 4'b1000);
    tick(RF - 1);
    check("R4 cool last cycle", {2'b0, gate_en}, 4'b0000);
    tick(1);
    check("R4 retry", {stat_n, gate_en}, 4'b1001);
    tick(SS - 1);
    check("R4 before requalify", {2'b0, gate_en}, 4'b0001);
    tick(1);
    check("R4 repeat latch", {stat_n, gate_en}, 4'b1000);
    oc_a[0] = 0;
    tick(RF + 2);
    check("R6 clear after retry", {stat_n, gate_en}, 4'b1101);
  endtask

  task automatic t_short_hold();  // R5 R6
    go_idle();
    hold_a = 1; cmd_a = 2'b10; tick(4);
    oc_a[1] = 1;
    tick(SS + 2);
    check("R5 hold reported", {stat_n, gate_en}, 4'b0110);
    tick(RF + 5);
    check("R5 hold stays on", {stat_n, gate_en}, 4'b0110);
    cmd_a[1] = 0;
    tick(3);
    check("R6 cmd low clears", {stat_n, gate_en}, 4'b1100);
    oc_a[1] = 0; hold_a = 0;
  endtask

  task automatic t_open_on();  // R7
    go_idle();
    cmd_a = 2'b01; tick(4);
    lowcur_a[0] = 1;
    tick(OS + 1);
    check("R7 before window", {stat_n, gate_en}, 4'b1101);
    tick(1);
    check("R7 open reported", {stat_n, gate_en}, 4'b1001);
    lowcur_a[0] = 0;
    tick(4);
    check("R7 open cleared", {stat_n, gate_en}, 4'b1101);
  endtask

  task automatic t_off_open();  // R8 R11
    go_idle();
    lowcur_a[1] = 1;
    tick(3);
    check("R8 off open status", {2'b0, stat_n}, 4'b0001);
    check("R11 irq on fault", {3'b0, irq_n}, 4'b0000);
    lowcur_a[1] = 0;
    tick(3);
    check("R8 off open cleared", {1'b0, irq_n, stat_n}, 4'b0111);
  endtask

  task automatic t_thermal();  // R9
    go_idle();
    cmd_a = 2'b11; tick(4);
    ot_a[0] = 1;
    tick(2);
    check("R9 thermal off", {stat_n, gate_en}, 4'b1010);
    ot_a[0] = 0;
    tick(3);
    check("R9 retry, status held", {stat_n, gate_en}, 4'b1011);
    cmd_a[0] = 0;
    tick(3);
    check("R9 cleared on cmd low", {stat_n, gate_en}, 4'b1110);
  endtask

  task automatic t_ovp();  // R10
    go_idle();
    cmd_a = 2'b11; tick(4);
    ovp_a = 1;
    tick(2);
    check("R10 ovp off", {stat_n, gate_en}, 4'b0000);
    check("R10 ovp irq", {3'b0, irq_n}, 4'b0000);
    ovp_a = 0;
    tick(2);
    check("R10 ovp recover", {stat_n, gate_en}, 4'b1111);
  endtask

  task automatic t_sleep_reset();  // R1
    go_idle();
    cmd_a = 2'b01; tick(4);
    oc_a[0] = 1;
    tick(SS + 3);
    check("R1 pre-sleep fault", {2'b0, stat_n}, 4'b0010);
    chip_en_a = 0;
    tick(3);
    check("R1 sleep forces off", {gate_en, stat_oe, irq_oe}, 4'b0000);
    oc_a[0] = 0; chip_en_a = 1;
    tick(4);
    check("R1 state reset", {stat_n, gate_en}, 4'b1101);
  endtask

  initial begin
    tick(3);
    check("R1 reset state", {gate_en, stat_oe, irq_oe}, 4'b0000);
    rst_n = 1;
    tick(2);
    t_glitch();
    t_short_latch();
    t_short_hold();
    t_open_on();
    t_off_open();
    t_thermal();
    t_ovp();
    t_sleep_reset();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule